// File: doc/BRIEF.md
# Gated 16-bit Up-Counter with Prescaler

This block is a 16-bit up-counter exposed as two byte registers. It advances either once per system clock or once per rising edge of an external clock pin, after a prescaler that divides those ticks by 1, 2, 4 or 8. Software loads the count one byte at a time, and each byte port always shows the live count.

A gate can qualify counting. The gate signal comes from a gate pin or from a comparator input, and an invert control chooses whether counting happens while that signal is high or low. External edges normally pass through a synchronizer clocked by the system clock. A bypass control feeds the raw pin to the edge detector instead; the asynchronous path is modelled only at the behavioural level. When the count wraps from FFFFh to zero, a sticky overflow flag is set, and it stays set until software clears it.

Top module: `gtmr16_top`

## Requirements
- R1: After reset the count is 0000h, the overflow flag is 0 and no falling edge is recorded on the external clock.
- R2: A low-byte write loads bits 7:0 and leaves bits 15:8 unchanged. A high-byte write loads bits 15:8 and leaves bits 7:0 unchanged. A write made in the same cycle as an increment wins, and that increment is lost.
- R3: Prescale code 0, 1, 2 or 3 gives one count increment per 1, 2, 4 or 8 qualified ticks. Any byte write clears the prescaler's partial progress.
- R4: An increment at FFFFh gives 0000h and sets the overflow flag. The flag stays at 1 until a clear pulse. When a wrap and a clear pulse fall in the same cycle, the flag ends at 1.
- R5: With source select 0, each system clock cycle is one tick. With source select 1, each rising edge on the external clock input is one tick.
- R6: In external mode, a rising edge is counted only after at least one falling edge has been seen since reset.
- R7: With sync bypass 0, external edges go through the synchronizer. With sync bypass 1, the raw pin is used. Either setting counts the same pulses. In internal mode the bypass setting has no effect on the count.
- R8: With gate enable 1, ticks count only while the selected gate signal equals the invert bit (1 counts while high, 0 counts while low). Gate select 0 picks the gate pin and 1 picks the comparator input. With gate enable 0, the gate is ignored.
- R9: With the on bit at 0, no tick is counted, whatever the gate and source settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_on | input | 1 | Counter run enable |
| cfg_ext_src | input | 1 | 0 internal ticks, 1 external rising edges |
| cfg_no_sync | input | 1 | 1 bypasses the external synchronizer |
| cfg_pre | input | 2 | Prescale code, divide by 2**code |
| cfg_gate_en | input | 1 | Gate qualification enable |
| cfg_gate_sel | input | 1 | 0 gate pin, 1 comparator input |
| cfg_gate_inv | input | 1 | Gate level that permits counting |
| ext_clk | input | 1 | External clock pin |
| gate_pin | input | 1 | Gate pin |
| cmp_in | input | 1 | Comparator result |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| cnt_lo | output | 8 | Live count bits 7:0 |
| cnt_hi | output | 8 | Live count bits 15:8 |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of actions can land in the same clock cycle. A wrap can coincide with a software flag clear, and an increment can coincide with a byte write. The bench causes the first by loading FFFFh and raising the run enable and the clear pulse for one cycle together; it then expects the flag to be 1 and the count 0000h. It causes the second by writing the low byte while the counter is running; it then expects the written value and an unchanged high byte.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   localparam int unsigned CNT_W  = 16;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PRE_W  = 2;

   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } tick_src_e;
endpackage

// File: rtl/gtmr_edge.sv
module gtmr_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   input  logic pin,
   output logic rise,
   output logic armed
);
   initial begin
      assert (STAGES >= 1 && STAGES <= 4)
         else $error("gtmr_edge: STAGES out of range");
   end

   logic [STAGES-1:0] chain;
   logic              sel_lvl;
   logic              prev_lvl;
   logic              fall_seen;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sel_lvl = bypass ? pin : chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl  <= 1'b0;
         fall_seen <= 1'b0;
      end else begin
         prev_lvl <= sel_lvl;
         if (prev_lvl && !sel_lvl) fall_seen <= 1'b1;
      end
   end

   assign rise  = sel_lvl && !prev_lvl && fall_seen;
   assign armed = fall_seen;

   // R6: once armed, the record of a falling edge is never lost
   p_armed_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
   parameter int unsigned PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [PRE_W-1:0] code,
   output logic             pulse
);
   localparam int unsigned PC_W = (1 << PRE_W) - 1;

   initial begin
      assert (PRE_W >= 1 && PRE_W <= 3)
         else $error("gtmr_prescale: PRE_W out of range");
   end

   logic [PC_W-1:0] pcnt;
   logic [PC_W-1:0] limit;

   always_comb begin
      limit = '0;
      for (int i = 0; i < PC_W; i++) begin
         if (i < int'(code)) limit[i] = 1'b1;
      end
   end

   assign pulse = tick && (pcnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt <= '0;
      else if (clr)   pcnt <= '0;
      else if (pulse) pcnt <= '0;
      else if (tick)  pcnt <= pcnt + 1'b1;
   end

   // R3: without ticks or a clear the partial count holds
   p_pre_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(pcnt));
   // R3: a write clears any partial progress
   p_pre_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pcnt == '0));
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   initial begin
      assert (CNT_W == 2 * BYTE_W)
         else $error("gtmr_count: count must be two bytes");
   end

   logic any_wr;
   logic wrap;

   assign any_wr = wr_lo || wr_hi;
   assign wrap   = inc && !any_wr && (cnt == MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (any_wr) begin
         if (wr_lo) cnt[BYTE_W-1:0]     <= wr_data;
         if (wr_hi) cnt[CNT_W-1:BYTE_W] <= wr_data;
      end else if (inc) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf <= 1'b0;
      else if (wrap)    ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
   end

   // R4: wrapping lands on zero with the flag raised
   p_wrap_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !any_wr && cnt == MAXV) |=> (ovf && cnt == '0));
   // R4: the flag holds without a clear
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);
   // R2: a low-byte-only write keeps the high byte
   p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (cnt[CNT_W-1:BYTE_W] == $past(cnt[CNT_W-1:BYTE_W])));
endmodule

// File: rtl/gtmr16_top.sv
module gtmr16_top
   import gtmr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_on,
   input  logic              cfg_ext_src,
   input  logic              cfg_no_sync,
   input  logic [PRE_W-1:0]  cfg_pre,
   input  logic              cfg_gate_en,
   input  logic              cfg_gate_sel,
   input  logic              cfg_gate_inv,
   input  logic              ext_clk,
   input  logic              gate_pin,
   input  logic              cmp_in,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              ovf_flag
);
   logic             ext_rise;
   logic             ext_armed;
   logic             gate_sig;
   logic             gate_ok;
   logic             src_tick;
   logic             tick;
   logic             pre_pulse;
   logic [CNT_W-1:0] cnt;
   tick_src_e        src;

   assign src      = tick_src_e'(cfg_ext_src);
   assign gate_sig = cfg_gate_sel ? cmp_in : gate_pin;
   assign gate_ok  = !cfg_gate_en || (gate_sig == cfg_gate_inv);
   assign src_tick = (src == SRC_EXT) ? ext_rise : 1'b1;
   assign tick     = cfg_on && gate_ok && src_tick;

   gtmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .bypass (cfg_no_sync),
      .pin    (ext_clk),
      .rise   (ext_rise),
      .armed  (ext_armed)
   );

   gtmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (wr_lo || wr_hi),
      .code  (cfg_pre),
      .pulse (pre_pulse)
   );

   gtmr_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (pre_pulse),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .ovf_clr (ovf_clr),
      .cnt     (cnt),
      .ovf     (ovf_flag)
   );

   assign cnt_lo = cnt[BYTE_W-1:0];
   assign cnt_hi = cnt[CNT_W-1:BYTE_W];

   // R9: when not running, only writes move the count
   p_off_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_on && !wr_lo && !wr_hi) |=> $stable(cnt));
   // R6: an external source without a recorded fall never counts
   p_need_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ext_src && !ext_armed && !wr_lo && !wr_hi) |=> $stable(cnt));
   // R8: a gate that blocks stops the count
   p_gate_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_gate_en && (gate_sig != cfg_gate_inv) && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: tb/gtmr16_tb.sv
module gtmr16_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_on = 0, cfg_ext_src = 0, cfg_no_sync = 0;
   logic [1:0] cfg_pre = 0;
   logic       cfg_gate_en = 0, cfg_gate_sel = 0, cfg_gate_inv = 0;
   logic       ext_clk = 0, gate_pin = 0, cmp_in = 0;
   logic       wr_lo = 0, wr_hi = 0, ovf_clr = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] cnt_lo, cnt_hi;
   logic       ovf_flag;
   int         total = 0;
   int         bad = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   gtmr16_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_ext_src(cfg_ext_src),
      .cfg_no_sync(cfg_no_sync), .cfg_pre(cfg_pre), .cfg_gate_en(cfg_gate_en),
      .cfg_gate_sel(cfg_gate_sel), .cfg_gate_inv(cfg_gate_inv), .ext_clk(ext_clk),
      .gate_pin(gate_pin), .cmp_in(cmp_in), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .ovf_clr(ovf_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .ovf_flag(ovf_flag)
   );

   typedef struct packed {
      logic [15:0] start;
      logic [1:0]  pre;
      logic [7:0]  n;
      logic        nosync;
      logic [15:0] expv;
      logic        expf;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{16'h0000, 2'd0, 8'd10, 1'b0, 16'h000A, 1'b0},
      '{16'h0010, 2'd1, 8'd9,  1'b0, 16'h0014, 1'b0},
      '{16'h1234, 2'd2, 8'd17, 1'b1, 16'h1238, 1'b0},
      '{16'h00FF, 2'd3, 8'd16, 1'b0, 16'h0101, 1'b0},
      '{16'h00FE, 2'd0, 8'd3,  1'b1, 16'h0101, 1'b0},
      '{16'hFFFE, 2'd0, 8'd3,  1'b0, 16'h0001, 1'b1},
      '{16'hFFFF, 2'd3, 8'd8,  1'b1, 16'h0000, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic wr_byte(input bit hi, input logic [7:0] d);
      @(negedge clk);
      wr_lo = !hi; wr_hi = hi; wr_data = d;
      @(negedge clk);
      wr_lo = 0; wr_hi = 0;
   endtask

   task automatic load(input logic [15:0] v);
      wr_byte(0, v[7:0]);
      wr_byte(1, v[15:8]);
   endtask

   task automatic run(input int n);
      @(negedge clk);
      cfg_on = 1;
      repeat (n) @(negedge clk);
      cfg_on = 0;
   endtask

   task automatic pulse_ext(input int k);
      for (int i = 0; i < k; i++) begin
         ext_clk = 1; repeat (6) @(negedge clk);
         ext_clk = 0; repeat (6) @(negedge clk);
      end
   endtask

   task automatic clr_flag();
      @(negedge clk); ovf_clr = 1;
      @(negedge clk); ovf_clr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 count", {cnt_hi, cnt_lo}, 16'h0000);
      check("R1 flag", ovf_flag, 1'b0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 R4 R5 R7: vector walk in internal mode
      foreach (VEC[i]) begin
         cfg_pre = VEC[i].pre;
         cfg_no_sync = VEC[i].nosync;
         clr_flag();
         load(VEC[i].start);
         run(int'(VEC[i].n));
         @(negedge clk);
         check("R3/R5 vector count", {cnt_hi, cnt_lo}, VEC[i].expv);
         check("R4 vector flag", ovf_flag, VEC[i].expf);
      end
      cfg_no_sync = 0;

      // R4: flag persists, then clear
      check("R4 sticky", ovf_flag, 1'b1);
      clr_flag();
      check("R4 cleared", ovf_flag, 1'b0);

      // R4: wrap and clear in the same cycle, set wins
      cfg_pre = 0;
      load(16'hFFFF);
      @(negedge clk); cfg_on = 1; ovf_clr = 1;
      @(negedge clk); cfg_on = 0; ovf_clr = 0;
      check("R4 same-cycle flag", ovf_flag, 1'b1);
      check("R4 same-cycle count", {cnt_hi, cnt_lo}, 16'h0000);
      clr_flag();

      // R2: byte writes keep the other byte
      load(16'hA55A);
      wr_byte(0, 8'h3C);
      check("R2 lo write keeps hi", {cnt_hi, cnt_lo}, 16'hA53C);
      wr_byte(1, 8'h81);
      check("R2 hi write keeps lo", {cnt_hi, cnt_lo}, 16'h813C);

      // R2: write wins over a same-cycle increment
      load(16'h0205);
      @(negedge clk); cfg_on = 1;
      @(negedge clk); wr_lo = 1; wr_data = 8'h40;
      @(negedge clk); wr_lo = 0; cfg_on = 0;
      check("R2 write beats inc", {cnt_hi, cnt_lo}, 16'h0240);

      // R3: a write clears prescaler progress
      cfg_pre = 3;
      load(16'h0000);
      run(5);
      wr_byte(0, 8'h00);
      run(5);
      check("R3 prescaler cleared", {cnt_hi, cnt_lo}, 16'h0000);
      run(3);
      check("R3 div8 after clear", {cnt_hi, cnt_lo}, 16'h0001);

      // R8: gate qualification
      cfg_pre = 0;
      load(16'h0000);
      cfg_gate_en = 1; cfg_gate_sel = 0; cfg_gate_inv = 1; gate_pin = 0;
      run(5);
      check("R8 pin low blocks", {cnt_hi, cnt_lo}, 16'h0000);
      gate_pin = 1; run(5);
      check("R8 pin high counts", {cnt_hi, cnt_lo}, 16'h0005);
      cfg_gate_inv = 0; gate_pin = 0; run(4);
      check("R8 inverted pin low counts", {cnt_hi, cnt_lo}, 16'h0009);
      cfg_gate_sel = 1; cfg_gate_inv = 1; cmp_in = 1; run(3);
      check("R8 comparator high counts", {cnt_hi, cnt_lo}, 16'h000C);
      cmp_in = 0; gate_pin = 1; run(3);
      check("R8 comparator low blocks", {cnt_hi, cnt_lo}, 16'h000C);
      cfg_gate_en = 0; run(2);
      check("R8 gate disabled ignored", {cnt_hi, cnt_lo}, 16'h000E);

      // R9: off stops counting even with a passing gate
      cfg_gate_en = 1; cfg_gate_sel = 0; cfg_gate_inv = 1; gate_pin = 1;
      repeat (6) @(negedge clk);
      check("R9 off frozen", {cnt_hi, cnt_lo}, 16'h000E);
      cfg_gate_en = 0;

      // R5 R6 R7: external source
      cfg_ext_src = 1;
      load(16'h0000);
      @(negedge clk); cfg_on = 1;
      pulse_ext(1);
      check("R6 first rise not counted", {cnt_hi, cnt_lo}, 16'h0000);
      pulse_ext(3);
      check("R5 external rises", {cnt_hi, cnt_lo}, 16'h0003);
      cfg_no_sync = 1;
      repeat (4) @(negedge clk);
      pulse_ext(2);
      check("R7 bypass counts same", {cnt_hi, cnt_lo}, 16'h0005);
      cfg_pre = 1;
      wr_byte(0, 8'h00);
      pulse_ext(4);
      check("R3/R5 external div2", {cnt_hi, cnt_lo}, 16'h0002);
      cfg_on = 0;
      repeat (6) @(negedge clk);
      pulse_ext(2);
      check("R9 external off frozen", {cnt_hi, cnt_lo}, 16'h0002);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule